// File: doc/BRIEF.md
# Pin Interrupt Controller

This block watches 32 general-purpose input pins and turns their activity into one interrupt request. The pins are split into two halves of 16: pins 0 to 15 form the low half and pins 16 to 31 the high half. Every control function has one 16-bit register for each half. Each pin passes through a two-flop synchroniser. Its event is then formed according to that pin's own configuration, which covers:

- edge or level triggering;
- polarity of the level;
- which edges count;
- whether an edge is held until software clears it, or shown for one cycle only.

A pending pin raises the interrupt only if its enable bit is set. When one or more enabled pins are pending, the block reports the number of the lowest one. Software reads and writes the registers through a simple synchronous port with a halfword address. It clears held events by writing ones to the status register.

Top module: `pin_irq_ctrl`

## Requirements
- R1: After reset the enable, edge-mode, hold, rise-pick and fall-pick registers of both halves read 0x0000, the polarity registers read 0xFFFF, no status bit is set while all pins are low, and irq_out and irq_valid are low.
- R2: The register is chosen by bus_addr[4:2]: 0 enable, 1 status, 2 edge-mode, 3 polarity, 4 hold, 5 fall-pick, 6 rise-pick. bus_addr[1] chooses the half: 0 selects pins 0–15 and 1 selects pins 16–31, with bit n of the data mapping to pin n of that half. A write updates only the selected register, every configuration register reads back what was written, and code 7 reads as zero.
- R3: A pin change driven between clock edges first shows in the status register after the third rising edge that follows the change, and not after the second.
- R4: With edge-mode bit 0 (level), the status bit is 1 exactly while the synchronised pin matches the polarity bit (1 = active high, 0 = active low). It follows the pin without latching, and a write of 1 to it has no effect.
- R5: With edge-mode bit 1, rise-pick bit 1 makes a 0-to-1 change an event and fall-pick bit 1 makes a 1-to-0 change an event. With both bits set, both changes are events. With neither bit set, no change is an event.
- R6: With edge-mode bit 1 and hold bit 1, an event sets the status bit and the bit stays set until a status write with a 1 in that position. Writing a 0 in that position leaves the bit set.
- R7: With edge-mode bit 1 and hold bit 0, each event sets the status bit for exactly one clock cycle.
- R8: When an event and a status write of 1 reach the same bit in the same cycle, the bit remains set.
- R9: irq_out and irq_valid are high exactly when at least one pin has both its status bit and its enable bit set. A status bit whose enable bit is clear stays readable and does not raise irq_out.
- R10: While irq_valid is high, irq_pin gives the lowest-numbered pin whose status and enable bits are both set. Pins 0–15 are therefore reported before pins 16–31.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| pin_in | input | 32 | Asynchronous pin inputs; bit n is pin n |
| bus_wr | input | 1 | Register write strobe, one cycle per write |
| bus_addr | input | 4 | Halfword address, bits 4 down to 1 of the byte address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr, combinational |
| irq_out | output | 1 | Combined interrupt request |
| irq_valid | output | 1 | Qualifies irq_pin |
| irq_pin | output | 5 | Lowest enabled pending pin number |

## Verification
The assertions relate each status bit to the event and clear mask of the previous cycle, and the reported pin to the pending vector. They make no assumption about pin timing, because every pin is synchronised before it is used. They do rely on the bus carrying exactly one write strobe per access, with the address stable during it. The stimulus drives pins and bus signals only on falling edges. It holds each pin level for at least three cycles so that every edge passes the synchroniser. The collision case lines up a clearing write with the third rising edge after a pin change.

// File: rtl/pirq_pkg.sv
package pirq_pkg;
  // register function code, taken from address bits [4:2]
  typedef enum logic [2:0] {
    FN_ENABLE = 3'd0,
    FN_STATUS = 3'd1,
    FN_EDGE   = 3'd2,
    FN_POLAR  = 3'd3,
    FN_HOLD   = 3'd4,
    FN_FALL   = 3'd5,
    FN_RISE   = 3'd6
  } pirq_fn_e;

  localparam int unsigned HALVES = 2;
  localparam int unsigned ADDR_W = 5;   // byte address width, bit 0 not carried
endpackage

// File: rtl/pirq_sync.sv
module pirq_sync #(
  parameter int unsigned W      = 16,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [STAGES-1:0][W-1:0] stage_q, stage_d;

  always_comb begin
    stage_d[0] = din;
    for (int k = 1; k < int'(STAGES); k++) stage_d[k] = stage_q[k-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= '0;
    else        stage_q <= stage_d;
  end

  assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/pirq_half.sv
module pirq_half #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pin_s,
  input  logic [W-1:0] edge_mode,
  input  logic [W-1:0] polar,
  input  logic [W-1:0] hold,
  input  logic [W-1:0] fall_pick,
  input  logic [W-1:0] rise_pick,
  input  logic [W-1:0] clr,
  output logic [W-1:0] status_q
);
  logic [W-1:0] prev_q, prev_d, status_d;
  logic [W-1:0] rise_hit, fall_hit, lvl, evt, held;

  always_comb begin
    rise_hit = pin_s & ~prev_q & rise_pick;
    fall_hit = ~pin_s & prev_q & fall_pick;
    lvl      = ~(pin_s ^ polar);
    evt      = (edge_mode & (rise_hit | fall_hit)) | (~edge_mode & lvl);
    held     = edge_mode & hold;
    // a fresh event wins over a clearing write on the same bit
    status_d = evt | (held & status_q & ~clr);
    prev_d   = pin_s;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q   <= '0;
      status_q <= '0;
    end else begin
      prev_q   <= prev_d;
      status_q <= status_d;
    end
  end

  assert_hold_stays_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(status_q & held & ~clr) & ~status_q) == '0));

  assert_event_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(evt) & ~status_q) == '0));

  assert_through_drops_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((status_q & ~$past(held) & ~$past(evt)) == '0));

  assert_level_follow_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(~edge_mode) & (status_q ^ $past(lvl))) == '0));
endmodule

// File: rtl/pirq_prio.sv
module pirq_prio #(
  parameter int unsigned N  = 32,
  parameter int unsigned IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  req,
  output logic          valid,
  output logic [IW-1:0] idx
);
  always_comb begin
    valid = |req;
    idx   = '0;
    for (int i = int'(N) - 1; i >= 0; i--) begin
      if (req[i]) idx = IW'(i);
    end
  end

  assert_pick_pending_R10: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> req[idx]);

  assert_pick_lowest_R10: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> ((req & ((N'(1) << idx) - N'(1))) == '0));

  assert_idle_empty_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !valid |-> (idx == '0));
endmodule

// File: rtl/pin_irq_ctrl.sv
module pin_irq_ctrl
  import pirq_pkg::*;
#(
  parameter  int unsigned HALF_W      = 16,
  parameter  int unsigned SYNC_STAGES = 2,
  localparam int unsigned NPIN        = HALVES * HALF_W,
  localparam int unsigned PIN_IW      = $clog2(NPIN)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NPIN-1:0]   pin_in,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:1] bus_addr,
  input  logic [HALF_W-1:0] bus_wdata,
  output logic [HALF_W-1:0] bus_rdata,
  output logic              irq_out,
  output logic              irq_valid,
  output logic [PIN_IW-1:0] irq_pin
);
  // reset: asserted asynchronously, released after two clock edges
  logic [1:0] rst_pipe_q;
  logic       core_rst_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign core_rst_n = rst_pipe_q[1];

  // address decode
  pirq_fn_e fn;
  logic     half;
  assign fn   = pirq_fn_e'(bus_addr[ADDR_W-1:2]);
  assign half = bus_addr[1];

  // configuration registers, one word per half
  logic [HALVES-1:0][HALF_W-1:0] en_q,   en_d;
  logic [HALVES-1:0][HALF_W-1:0] edge_q, edge_d;
  logic [HALVES-1:0][HALF_W-1:0] pol_q,  pol_d;
  logic [HALVES-1:0][HALF_W-1:0] hold_q, hold_d;
  logic [HALVES-1:0][HALF_W-1:0] fall_q, fall_d;
  logic [HALVES-1:0][HALF_W-1:0] rise_q, rise_d;
  logic [HALVES-1:0][HALF_W-1:0] clr_mask;
  logic [HALVES-1:0][HALF_W-1:0] status_w;

  always_comb begin
    en_d     = en_q;
    edge_d   = edge_q;
    pol_d    = pol_q;
    hold_d   = hold_q;
    fall_d   = fall_q;
    rise_d   = rise_q;
    clr_mask = '0;
    if (bus_wr) begin
      unique case (fn)
        FN_ENABLE: en_d[half]     = bus_wdata;
        FN_STATUS: clr_mask[half] = bus_wdata;
        FN_EDGE:   edge_d[half]   = bus_wdata;
        FN_POLAR:  pol_d[half]    = bus_wdata;
        FN_HOLD:   hold_d[half]   = bus_wdata;
        FN_FALL:   fall_d[half]   = bus_wdata;
        FN_RISE:   rise_d[half]   = bus_wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge core_rst_n) begin
    if (!core_rst_n) begin
      en_q   <= '0;
      edge_q <= '0;
      pol_q  <= '1;
      hold_q <= '0;
      fall_q <= '0;
      rise_q <= '0;
    end else begin
      en_q   <= en_d;
      edge_q <= edge_d;
      pol_q  <= pol_d;
      hold_q <= hold_d;
      fall_q <= fall_d;
      rise_q <= rise_d;
    end
  end

  always_comb begin
    unique case (fn)
      FN_ENABLE: bus_rdata = en_q[half];
      FN_STATUS: bus_rdata = status_w[half];
      FN_EDGE:   bus_rdata = edge_q[half];
      FN_POLAR:  bus_rdata = pol_q[half];
      FN_HOLD:   bus_rdata = hold_q[half];
      FN_FALL:   bus_rdata = fall_q[half];
      FN_RISE:   bus_rdata = rise_q[half];
      default:   bus_rdata = '0;
    endcase
  end

  // input synchronisation
  logic [NPIN-1:0] pin_s;

  pirq_sync #(.W(NPIN), .STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(core_rst_n),
    .din  (pin_in),
    .dout (pin_s)
  );

  // per-half event detection and status
  for (genvar h = 0; h < int'(HALVES); h++) begin : g_half
    pirq_half #(.W(HALF_W)) u_half (
      .clk      (clk),
      .rst_n    (core_rst_n),
      .pin_s    (pin_s[h*HALF_W +: HALF_W]),
      .edge_mode(edge_q[h]),
      .polar    (pol_q[h]),
      .hold     (hold_q[h]),
      .fall_pick(fall_q[h]),
      .rise_pick(rise_q[h]),
      .clr      (clr_mask[h]),
      .status_q (status_w[h])
    );
  end

  // request combining and pin selection
  logic [NPIN-1:0] pending;
  assign pending = status_w & en_q;

  pirq_prio #(.N(NPIN), .IW(PIN_IW)) u_prio (
    .clk  (clk),
    .rst_n(core_rst_n),
    .req  (pending),
    .valid(irq_valid),
    .idx  (irq_pin)
  );

  assign irq_out = irq_valid;

  assert_enable_gates_R9: assert property (@(posedge clk) disable iff (!core_rst_n)
    irq_out |-> en_q[irq_pin / HALF_W][irq_pin % HALF_W]);
endmodule

// File: tb/sim_pin_irq_ctrl.sv
`timescale 1ns/1ps
module sim_pin_irq_ctrl;
  localparam logic [2:0] F_EN = 3'd0, F_ST = 3'd1, F_EDGE = 3'd2, F_POL = 3'd3,
                         F_HOLD = 3'd4, F_FALL = 3'd5, F_RISE = 3'd6;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] pin_in;
  logic        bus_wr;
  logic [4:1]  bus_addr;
  logic [15:0] bus_wdata;
  logic [15:0] bus_rdata;
  logic        irq_out, irq_valid;
  logic [4:0]  irq_pin;

  int total = 0;
  int bad   = 0;

  always #2.5 clk = ~clk;

  pin_irq_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_out(irq_out), .irq_valid(irq_valid), .irq_pin(irq_pin)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] fn, input logic h, input logic [15:0] d);
    bus_addr  = {fn, h};
    bus_wdata = d;
    bus_wr    = 1'b1;
    @(posedge clk);
    @(negedge clk);
    bus_wr    = 1'b0;
  endtask

  task automatic rd(input logic [2:0] fn, input logic h, output logic [15:0] v);
    bus_addr = {fn, h};
    #0.5;
    v = bus_rdata;
  endtask

  task automatic test_reset;
    logic [15:0] v;
    rd(F_EN, 0, v);   chk("R1 enable lo", v, 16'h0000);
    rd(F_EN, 1, v);   chk("R1 enable hi", v, 16'h0000);
    rd(F_EDGE, 0, v); chk("R1 edge lo", v, 16'h0000);
    rd(F_POL, 1, v);  chk("R1 polar hi", v, 16'hFFFF);
    rd(F_HOLD, 0, v); chk("R1 hold lo", v, 16'h0000);
    rd(F_RISE, 1, v); chk("R1 rise hi", v, 16'h0000);
    rd(F_ST, 0, v);   chk("R1 status lo", v, 16'h0000);
    chk("R1 irq_out", irq_out, 0);
    chk("R1 irq_valid", irq_valid, 0);
  endtask

  task automatic test_regmap;
    logic [15:0] v;
    wr(F_EDGE, 0, 16'h00F0);
    wr(F_RISE, 1, 16'hA5A5);
    rd(F_EDGE, 0, v); chk("R2 edge lo readback", v, 16'h00F0);
    rd(F_RISE, 1, v); chk("R2 rise hi readback", v, 16'hA5A5);
    rd(F_RISE, 0, v); chk("R2 rise lo untouched", v, 16'h0000);
    rd(F_EDGE, 1, v); chk("R2 edge hi untouched", v, 16'h0000);
    rd(3'd7, 0, v);   chk("R2 code 7 reads zero", v, 16'h0000);
    wr(F_EDGE, 0, 16'h0000);
    wr(F_RISE, 1, 16'h0000);
  endtask

  task automatic test_level;
    logic [15:0] v;
    pin_in[3] = 1'b1;
    tick(2); rd(F_ST, 0, v); chk("R3 not yet after two edges", v, 16'h0000);
    tick(1); rd(F_ST, 0, v); chk("R3 R4 active high seen", v, 16'h0008);
    wr(F_ST, 0, 16'h0008);
    rd(F_ST, 0, v); chk("R4 clear ignored in level", v, 16'h0008);
    pin_in[3] = 1'b0;
    tick(3); rd(F_ST, 0, v); chk("R4 follows pin low", v, 16'h0000);
    wr(F_POL, 0, 16'hFFF7);
    tick(1); rd(F_ST, 0, v); chk("R4 active low seen", v, 16'h0008);
    wr(F_POL, 0, 16'hFFFF);
    tick(1); rd(F_ST, 0, v); chk("R4 restored polarity", v, 16'h0000);
  endtask

  task automatic test_hold_rise;
    logic [15:0] v;
    wr(F_EDGE, 0, 16'h01E0);   // pins 5..8 edge mode
    wr(F_HOLD, 0, 16'h01E0);
    wr(F_RISE, 0, 16'h00A0);   // pin 5 rise, pin 7 rise
    wr(F_FALL, 0, 16'h00C0);   // pin 6 fall, pin 7 fall
    tick(1);
    pin_in[5] = 1'b1;
    tick(3); rd(F_ST, 0, v); chk("R5 R6 rising edge held", v, 16'h0020);
    pin_in[5] = 1'b0;
    tick(3); rd(F_ST, 0, v); chk("R5 falling ignored on rise-only", v, 16'h0020);
    wr(F_ST, 0, 16'h0000);
    rd(F_ST, 0, v); chk("R6 zero write keeps bit", v, 16'h0020);
    wr(F_ST, 0, 16'h0020);
    rd(F_ST, 0, v); chk("R6 one write clears bit", v, 16'h0000);
  endtask

  task automatic test_edge_picks;
    logic [15:0] v;
    pin_in[6] = 1'b1;
    tick(3); rd(F_ST, 0, v); chk("R5 rise ignored on fall-only", v, 16'h0000);
    pin_in[6] = 1'b0;
    tick(3); rd(F_ST, 0, v); chk("R5 fall-only sees fall", v, 16'h0040);
    wr(F_ST, 0, 16'h0040);
    pin_in[7] = 1'b1;
    tick(3); rd(F_ST, 0, v); chk("R5 both picks rise", v, 16'h0080);
    wr(F_ST, 0, 16'h0080);
    pin_in[7] = 1'b0;
    tick(3); rd(F_ST, 0, v); chk("R5 both picks fall", v, 16'h0080);
    wr(F_ST, 0, 16'h0080);
    pin_in[8] = 1'b1;
    tick(3);
    pin_in[8] = 1'b0;
    tick(3); rd(F_ST, 0, v); chk("R5 no picks no event", v, 16'h0000);
  endtask

  task automatic test_through;
    logic [15:0] v;
    wr(F_EDGE, 0, 16'h03E0);   // add pin 9, hold bit left 0
    wr(F_RISE, 0, 16'h02A0);
    tick(1);
    pin_in[9] = 1'b1;
    tick(3); rd(F_ST, 0, v); chk("R7 through pulse high", v, 16'h0200);
    tick(1); rd(F_ST, 0, v); chk("R7 through pulse gone", v, 16'h0000);
    pin_in[9] = 1'b0;
    tick(3);
  endtask

  task automatic test_collision;
    logic [15:0] v;
    pin_in[5] = 1'b1;
    tick(3); rd(F_ST, 0, v); chk("R8 first event held", v, 16'h0020);
    pin_in[5] = 1'b0;
    tick(3);
    pin_in[5] = 1'b1;
    tick(2);
    wr(F_ST, 0, 16'h0020);     // lands on the event's edge
    rd(F_ST, 0, v); chk("R8 event beats clear", v, 16'h0020);
    wr(F_ST, 0, 16'h0020);
    rd(F_ST, 0, v); chk("R8 later clear works", v, 16'h0000);
    pin_in[5] = 1'b0;
    tick(3);
  endtask

  task automatic test_irq;
    logic [15:0] v;
    pin_in[20] = 1'b1;               // high half bit 4, level active high
    tick(3);
    rd(F_ST, 1, v); chk("R9 status visible while disabled", v, 16'h0010);
    chk("R9 disabled no irq", irq_out, 0);
    wr(F_EN, 1, 16'h0010);
    chk("R9 irq on enable", irq_out, 1);
    chk("R9 valid on enable", irq_valid, 1);
    chk("R10 pin 20", irq_pin, 20);
    pin_in[2] = 1'b1;
    tick(3);
    chk("R10 disabled low pin not chosen", irq_pin, 20);
    wr(F_EN, 0, 16'h0004);
    chk("R10 low half first", irq_pin, 2);
    pin_in[17] = 1'b1;
    tick(3);
    wr(F_EN, 1, 16'h0012);
    chk("R10 pin 2 still lowest", irq_pin, 2);
    wr(F_EN, 0, 16'h0000);
    chk("R10 lowest in high half", irq_pin, 17);
    pin_in[20] = 1'b0; pin_in[17] = 1'b0; pin_in[2] = 1'b0;
    tick(3);
    chk("R9 irq drops", irq_out, 0);
    chk("R9 valid drops", irq_valid, 0);
  endtask

  initial begin
    #1_000_000;
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; pin_in = '0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    tick(5);
    test_reset;
    test_regmap;
    test_level;
    test_hold_rise;
    test_edge_picks;
    test_through;
    test_collision;
    test_irq;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule